// File: doc/BRIEF.md
# Rate-Normalized CIC Decimator for I/Q Streams

This block reduces the sample rate of a paired I/Q stream with a four-stage cascaded integrator-comb filter, where the differential delay is one. The decimation rate can be changed while the block runs. Bit growth in a CIC filter rises as the fourth power of the rate. The block removes that growth by shifting the last comb result right by an amount taken from a rate-indexed table, and it uses no multiplier anywhere. As a result, a steady input gives about the same output amplitude at every rate from 1 to 256.

Software writes a total decimation request together with a flag that says whether a decimate-by-2 half-band filter follows this block. When the flag is set, this block takes half of the request and leaves the last factor of 2 to the half-band filter. When the flag is clear, this block takes the whole request. For example, with a 64 MS/s input, a total of 160 with the flag clear gives one output pair every 160 input pairs, which is 400 kS/s. A total of 320 with the flag set gives a CIC rate of 160, and the half-band filter then brings the stream to 200 kS/s.

A small state machine suppresses the results that the comb delay line has not yet settled. It has two states. FILL is entered at reset and after every configuration write, and in this state comb results are produced but not presented. RUN is entered from FILL when the fourth comb strobe after entry occurs, and in this state every comb strobe is presented. RUN returns to FILL on a configuration write.

Top module: `cic_decim_norm`

## Requirements
- R1: After reset, out_valid is 0, out_i and out_q are 0, and cic_rate is 1.
- R2: One cycle after cfg_we, cic_rate holds the CIC rate. With cfg_hb=1 this is cfg_total shifted right by one bit, and with cfg_hb=0 it is cfg_total itself. A result of 0 is raised to 1, and a result above 256 is lowered to 256. cic_rate stays unchanged while cfg_we is low.
- R3: Each presented output equals the input convolved with the fourth power of an R-tap boxcar, where R is the CIC rate. The newest input used is the one accepted three samples before the R-th input of the current period. The sum is arithmetically shifted right by ceil(4·log2 R), and the low 16 bits are kept.
- R4: The shift table covers every CIC rate up to 256, including rates above 128. A steady full-scale input of −32768 or +32767 yields an output of the same sign, with a magnitude between half and all of the input magnitude, and it never wraps.
- R5: out_valid pulses once for every R accepted inputs. It is high in the second cycle after the clock edge that accepts the R-th input of a period.
- R6: After reset or a configuration write, the first four decimation periods produce no out_valid. Every later period produces one. out_valid is 0 in the cycle after cfg_we.
- R7: Cycles with in_valid low have no effect on the filter state or the counting, whatever the data on in_i and in_q.
- R8: A configuration write discards any partly counted period, so that counting restarts from the first input accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_total | input | 10 | Requested total decimation |
| cfg_hb | input | 1 | 1 when a half-band decimate-by-2 stage follows |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase input |
| in_q | input | 16 | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed normalized in-phase output |
| out_q | output | 16 | Signed normalized quadrature output |
| cic_rate | output | 9 | CIC share of the decimation in effect |

## Verification
The CIC rate is due on the cycle after the write. The bench checks it at the next falling edge. For every R-th accepted input, the bench computes the expected output pair from its own boxcar model. It marks that pair as due two clock cycles after the accepting edge, skipping the first four periods after each configuration. A monitor samples one nanosecond after every rising edge and requires out_valid exactly in the cycles where a pair is due, with the matching values. A strobe that arrives early, late, missing or uninvited is therefore reported against the timing or warm-up requirement.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } warm_state_e;

    // Smallest s with 2**s >= r**4; evaluated only at elaboration.
    function automatic int norm_shift(input int r);
        longint p;
        int     s;
        p = longint'(r) * longint'(r) * longint'(r) * longint'(r);
        s = 0;
        while ((longint'(1) << s) < p) s++;
        return s;
    endfunction

endpackage

// File: rtl/cic_rate_ctrl.sv
`timescale 1ns/1ps
module cic_rate_ctrl #(
    parameter int STAGES = 4,
    parameter int RMAX   = 256,
    parameter int TW     = 10,
    parameter int RW     = 9,
    parameter int SH_W   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [TW-1:0]   cfg_total,
    input  logic            cfg_hb,
    input  logic            in_valid,
    output logic [RW-1:0]   rate,
    output logic [SH_W-1:0] shift,
    output logic            comb_en,
    output logic            comb_clr,
    output logic            emit
);
    import cic_pkg::*;

    localparam int WARM_W = $clog2(STAGES + 1);

    logic [TW-1:0]   cic_share;
    logic [RW-1:0]   rate_d;
    logic [RW-1:0]   rate_q;
    logic [RW-1:0]   cnt_q;
    logic            dec_stb_q;
    warm_state_e     state_q;
    warm_state_e     state_d;
    logic [WARM_W-1:0] warm_q;
    logic [WARM_W-1:0] warm_d;
    logic [SH_W-1:0] shift_tbl [RMAX+1];

    // Rate-to-shift table, one constant per CIC rate 0..RMAX.
    for (genvar g = 0; g <= RMAX; g++) begin : g_shift
        localparam logic [SH_W-1:0] SV = SH_W'(norm_shift(g));
        assign shift_tbl[g] = SV;
    end

    // Half-band split and clamping of the requested total.
    always_comb begin
        cic_share = cfg_hb ? (cfg_total >> 1) : cfg_total;
        if (cic_share == '0) begin
            rate_d = RW'(1);
        end else if (cic_share > TW'(RMAX)) begin
            rate_d = RW'(RMAX);
        end else begin
            rate_d = RW'(cic_share);
        end
    end

    // Rate register and decimation counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q    <= RW'(1);
            cnt_q     <= '0;
            dec_stb_q <= 1'b0;
        end else if (cfg_we) begin
            rate_q    <= rate_d;
            cnt_q     <= '0;
            dec_stb_q <= 1'b0;
        end else begin
            dec_stb_q <= 1'b0;
            if (in_valid) begin
                if (cnt_q == rate_q - RW'(1)) begin
                    cnt_q     <= '0;
                    dec_stb_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + RW'(1);
                end
            end
        end
    end

    // Warm-up state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            warm_q  <= '0;
        end else begin
            state_q <= state_d;
            warm_q  <= warm_d;
        end
    end

    // Next state: FILL -> RUN after STAGES comb strobes; any -> FILL on write.
    always_comb begin
        state_d = state_q;
        warm_d  = warm_q;
        if (cfg_we) begin
            state_d = ST_FILL;
            warm_d  = '0;
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    if (dec_stb_q) begin
                        if (warm_q == WARM_W'(STAGES - 1)) begin
                            state_d = ST_RUN;
                            warm_d  = '0;
                        end else begin
                            warm_d = warm_q + WARM_W'(1);
                        end
                    end
                end
                ST_RUN: begin
                    state_d = ST_RUN;
                end
                default: begin
                    state_d = ST_FILL;
                end
            endcase
        end
    end

    // Outputs of the state machine.
    always_comb begin
        comb_en  = dec_stb_q && !cfg_we;
        comb_clr = cfg_we;
        unique case (state_q)
            ST_FILL: emit = 1'b0;
            ST_RUN:  emit = dec_stb_q && !cfg_we;
            default: emit = 1'b0;
        endcase
    end

    assign rate  = rate_q;
    assign shift = shift_tbl[rate_q];

endmodule

// File: rtl/cic_integ_chain.sv
`timescale 1ns/1ps
module cic_integ_chain #(
    parameter int DW     = 16,
    parameter int ACC_W  = 48,
    parameter int STAGES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [DW-1:0]    din,
    output logic signed [ACC_W-1:0] dout
);
    logic signed [ACC_W-1:0] tap [STAGES];
    logic signed [ACC_W-1:0] din_ext;

    assign din_ext = {{(ACC_W-DW){din[DW-1]}}, din};

    // Each stage adds the registered value of the stage before it.
    for (genvar s = 0; s < STAGES; s++) begin : g_int
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] feed;
        if (s == 0) begin : g_first
            assign feed = din_ext;
        end else begin : g_next
            assign feed = tap[s-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (en) begin
                acc_q <= acc_q + feed;
            end
        end
        assign tap[s] = acc_q;
    end

    assign dout = tap[STAGES-1];

endmodule

// File: rtl/cic_comb_chain.sv
`timescale 1ns/1ps
module cic_comb_chain #(
    parameter int DW     = 16,
    parameter int ACC_W  = 48,
    parameter int STAGES = 4,
    parameter int SH_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    emit,
    input  logic [SH_W-1:0]         shift,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [DW-1:0]    dout
);
    logic signed [ACC_W-1:0] stg [STAGES+1];
    logic signed [DW-1:0]    sliced;
    logic signed [DW-1:0]    dout_q;

    assign stg[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_comb
        logic signed [ACC_W-1:0] dly_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q <= '0;
            end else if (clr) begin
                dly_q <= '0;
            end else if (en) begin
                dly_q <= stg[s];
            end
        end
        assign stg[s+1] = stg[s] - dly_q;
    end

    // Gain normalization: arithmetic right shift, keep the low word.
    assign sliced = DW'(stg[STAGES] >>> shift);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (emit) begin
            dout_q <= sliced;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/cic_decim_norm.sv
`timescale 1ns/1ps
module cic_decim_norm #(
    parameter  int DW     = 16,
    parameter  int STAGES = 4,
    parameter  int RMAX   = 256,
    localparam int TW     = $clog2(2*RMAX + 1),
    localparam int RW     = $clog2(RMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [TW-1:0] cfg_total,
    input  logic          cfg_hb,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          out_valid,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q,
    output logic [RW-1:0] cic_rate
);
    localparam int GROWTH = STAGES * $clog2(RMAX);
    localparam int ACC_W  = DW + GROWTH;
    localparam int SH_W   = $clog2(GROWTH + 1);
    localparam int NCH    = 2;

    logic [SH_W-1:0] shift;
    logic            comb_en;
    logic            comb_clr;
    logic            emit;
    logic            out_valid_q;
    logic [DW-1:0]   ch_in  [NCH];
    logic [DW-1:0]   ch_out [NCH];

    cic_rate_ctrl #(
        .STAGES (STAGES),
        .RMAX   (RMAX),
        .TW     (TW),
        .RW     (RW),
        .SH_W   (SH_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_total (cfg_total),
        .cfg_hb    (cfg_hb),
        .in_valid  (in_valid),
        .rate      (cic_rate),
        .shift     (shift),
        .comb_en   (comb_en),
        .comb_clr  (comb_clr),
        .emit      (emit)
    );

    assign ch_in[0] = in_i;
    assign ch_in[1] = in_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [ACC_W-1:0] integ_out;
        logic signed [DW-1:0]    comb_out;

        cic_integ_chain #(
            .DW     (DW),
            .ACC_W  (ACC_W),
            .STAGES (STAGES)
        ) u_integ (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (ch_in[c]),
            .dout  (integ_out)
        );

        cic_comb_chain #(
            .DW     (DW),
            .ACC_W  (ACC_W),
            .STAGES (STAGES),
            .SH_W   (SH_W)
        ) u_comb (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (comb_clr),
            .en    (comb_en),
            .emit  (emit),
            .shift (shift),
            .din   (integ_out),
            .dout  (comb_out)
        );

        assign ch_out[c] = comb_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= emit;
        end
    end

    assign out_valid = out_valid_q;
    assign out_i     = ch_out[0];
    assign out_q     = ch_out[1];

endmodule

// File: rtl/cic_decim_norm_chk.sv
`timescale 1ns/1ps
module cic_decim_norm_chk #(
    parameter int RMAX = 256,
    parameter int TW   = 10,
    parameter int RW   = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [TW-1:0] cfg_total,
    input logic          cfg_hb,
    input logic          in_valid,
    input logic          out_valid,
    input logic [RW-1:0] cic_rate
);
    AST_RATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cic_rate >= RW'(1)) && (cic_rate <= RW'(RMAX))); // R2

    AST_SPLIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_hb && (cfg_total >= TW'(1)) && (cfg_total <= TW'(RMAX))
        |=> cic_rate == RW'($past(cfg_total))); // R2

    AST_SPLIT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_hb && (cfg_total >= TW'(2)) && (cfg_total <= TW'(2*RMAX + 1))
        |=> cic_rate == RW'($past(cfg_total) >> 1)); // R2

    AST_SPLIT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_hb && (cfg_total > TW'(RMAX))
        |=> cic_rate == RW'(RMAX)); // R2

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cic_rate)); // R2

    AST_QUIET_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !out_valid); // R6

    AST_OUT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R5

endmodule

bind cic_decim_norm cic_decim_norm_chk #(
    .RMAX (RMAX),
    .TW   (TW),
    .RW   (RW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_total (cfg_total),
    .cfg_hb    (cfg_hb),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .cic_rate  (cic_rate)
);

// File: tb/cic_decim_norm_bench.sv
`timescale 1ns/1ps
module cic_decim_norm_bench;

    localparam int NST  = 4;
    localparam int HSZ  = 4096;
    localparam int QSZ  = 256;

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [9:0]  cfg_total;
    logic        cfg_hb;
    logic        in_valid;
    logic [15:0] in_i;
    logic [15:0] in_q;
    logic        out_valid;
    logic [15:0] out_i;
    logic [15:0] out_q;
    logic [8:0]  cic_rate;

    cic_decim_norm u_cic_decim_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_total (cfg_total),
        .cfg_hb    (cfg_hb),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q),
        .cic_rate  (cic_rate)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int     nchk = 0;
    int     nfail = 0;
    int     cyc = 0;
    longint hist_i [HSZ];
    longint hist_q [HSZ];
    longint h      [1024];
    longint tmp    [1024];
    int     hlen;
    int     nidx = 0;
    int     rcur = 1;
    int     scur = 0;
    int     since = 0;
    int     q_due [QSZ];
    logic [15:0] q_i [QSZ];
    logic [15:0] q_q [QSZ];
    string  q_tag [QSZ];
    int     qh = 0;
    int     qt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int model_rate(input int total, input bit hb);
        int r;
        r = hb ? total / 2 : total;
        if (r < 1) r = 1;
        if (r > 256) r = 256;
        return r;
    endfunction

    function automatic int model_shift(input int r);
        longint p;
        int s;
        p = longint'(r) * r * r * r;
        s = 0;
        while ((longint'(1) << s) < p) s++;
        return s;
    endfunction

    // Impulse response: boxcar of length r convolved with itself four times.
    task automatic build_h(input int r);
        for (int k = 0; k < 1024; k++) h[k] = 0;
        h[0] = 1;
        hlen = 1;
        for (int st = 0; st < NST; st++) begin
            for (int k = 0; k < hlen + r - 1; k++) begin
                longint acc;
                acc = 0;
                for (int m = 0; m < r; m++) begin
                    if (k - m >= 0 && k - m < hlen) acc += h[k - m];
                end
                tmp[k] = acc;
            end
            hlen = hlen + r - 1;
            for (int k = 0; k < hlen; k++) h[k] = tmp[k];
        end
    endtask

    function automatic logic [15:0] model_out(input bit use_q, input int n);
        longint y;
        y = 0;
        for (int j = 0; j < hlen; j++) begin
            int idx;
            idx = n - 3 - j;
            if (idx >= 0) y += h[j] * (use_q ? hist_q[idx % HSZ] : hist_i[idx % HSZ]);
        end
        return 16'(y >>> scur);
    endfunction

    task automatic do_cfg(input int total, input bit hb);
        @(negedge clk);
        cfg_total = 10'(total);
        cfg_hb    = hb;
        cfg_we    = 1'b1;
        in_valid  = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        rcur   = model_rate(total, hb);
        scur   = model_shift(rcur);
        since  = 0;
        build_h(rcur);
        chk(cic_rate == 9'(rcur), "R2", "cic_rate after write", cic_rate, rcur);
    endtask

    task automatic drive(input bit v, input logic [15:0] xi, input logic [15:0] xq,
                         input string tag);
        @(negedge clk);
        in_valid = v;
        in_i     = xi;
        in_q     = xq;
        if (v) begin
            hist_i[nidx % HSZ] = longint'($signed(xi));
            hist_q[nidx % HSZ] = longint'($signed(xq));
            since++;
            if ((since % rcur) == 0 && (since / rcur) > NST) begin
                q_due[qt] = cyc + 2;
                q_i[qt]   = model_out(1'b0, nidx);
                q_q[qt]   = model_out(1'b1, nidx);
                q_tag[qt] = tag;
                qt = (qt + 1) % QSZ;
            end
            nidx++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 16'($urandom), 16'($urandom), "R7");
    endtask

    task automatic run_random(input int nval, input int gap_pct, input string tag);
        int done;
        done = 0;
        while (done < nval) begin
            if (($urandom % 100) < gap_pct) begin
                drive(1'b0, 16'($urandom), 16'($urandom), tag);
            end else begin
                drive(1'b1, 16'($urandom), 16'($urandom), tag);
                done++;
            end
        end
    endtask

    task automatic run_dc(input int nval, input logic [15:0] x, input string tag);
        for (int k = 0; k < nval; k++) drive(1'b1, x, x, tag);
    endtask

    // Output monitor, one nanosecond after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (out_valid) begin
                if (qh != qt && q_due[qh] == cyc) begin
                    chk(1'b1, "R5", "strobe timing", 1, 1);
                    chk(out_i == q_i[qh], q_tag[qh], "out_i",
                        longint'($signed(out_i)), longint'($signed(q_i[qh])));
                    chk(out_q == q_q[qh], q_tag[qh], "out_q",
                        longint'($signed(out_q)), longint'($signed(q_q[qh])));
                    qh = (qh + 1) % QSZ;
                end else begin
                    chk(1'b0, "R6", "unexpected out_valid", 1, 0);
                end
            end else if (qh != qt && q_due[qh] == cyc) begin
                chk(1'b0, "R5", "missing out_valid", 0, 1);
                qh = (qh + 1) % QSZ;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R5 watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1957));
        for (int k = 0; k < HSZ; k++) begin
            hist_i[k] = 0;
            hist_q[k] = 0;
        end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_total = '0; cfg_hb = 1'b0;
        in_valid = 1'b0; in_i = '0; in_q = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_i == 16'd0, "R1", "out_i after reset", out_i, 0);
        chk(out_q == 16'd0, "R1", "out_q after reset", out_q, 0);
        chk(cic_rate == 9'd1, "R1", "cic_rate after reset", cic_rate, 1);

        // R3 and R7: small rate, random data with gaps
        do_cfg(5, 1'b0);
        run_random(60, 30, "R3");
        idle(4);

        // R2 split and R4 full-scale negative DC at rate 96
        do_cfg(192, 1'b1);
        run_dc(96 * 7, 16'h8000, "R4");
        idle(4);

        // R5 total 160 without half-band, positive full scale
        do_cfg(160, 1'b0);
        run_dc(160 * 7, 16'h7FFF, "R4");
        idle(4);

        // R5 total 320 with half-band, random data
        do_cfg(320, 1'b1);
        run_random(160 * 6, 10, "R3");
        idle(4);

        // R4 top of the range, rate 256
        do_cfg(256, 1'b0);
        run_dc(256 * 7, 16'h8000, "R4");
        idle(4);

        // R3 non-power-of-two rate above 128
        do_cfg(200, 1'b0);
        run_random(200 * 6, 20, "R3");
        idle(4);

        // R5 rate 1: back-to-back outputs after warm-up
        do_cfg(1, 1'b0);
        run_random(24, 0, "R5");
        idle(4);

        // R8 partial period discarded by a rewrite
        do_cfg(7, 1'b0);
        run_random(3, 0, "R8");
        idle(2);
        do_cfg(7, 1'b0);
        run_random(7 * 7, 25, "R8");
        idle(4);

        // R2 clamping corners
        do_cfg(0, 1'b0);
        do_cfg(600, 1'b0);
        do_cfg(700, 1'b1);
        do_cfg(1, 1'b1);
        idle(4);

        chk(qh == qt, "R5", "outstanding expected outputs", qt - qh, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule